// File: doc/BRIEF.md
# Folded GF(2^m) A·B² Unit

This block computes Y = A·B² mod P(x) over a binary extension field in polynomial basis. A small array of T cell rows is reused over N = ceil(M/T) rounds. Each row multiplies the running value by the square of the field generator, reduces it, and adds A gated by one bit of B. B is zero-extended to N·T bits and cut into N digits of T bits. One digit is consumed per round, starting with the most significant digit and its highest bit. After the last round the array holds the result.

The reduction polynomial is supplied as its M low coefficients, with the x^M term implied. From it the block derives, with combinational logic, the reduced form of x^(M+1), so that each row can fold both overflow bits in one step. Each row has its own stage register, and data flows one way through the rows. A round therefore takes T cycles, and a complete operation takes N·T cycles. A start pulse captures the operands. The busy output is high for the whole operation. A one-cycle done pulse marks the result, which then stays stable until the next start.

The M and T parameters select the field width and the fold factor. The arithmetic result is the same for every T from 1 to M. Only the row count and the cycle count change.

Top module: `gf_sqmul_fold`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy, done and y are all 0.
- R2: A start that is high at a clock edge while busy is low makes busy high from the next cycle.
- R3: When done is high, y equals A·B·B mod P for the A, B and P captured at the start edge. Bit j of each of a_in, b_in, poly_in and y is the coefficient of x^j, and the x^M term of P is implied.
- R4: done is first seen high exactly N·T clock edges after the edge that sampled start, where N = ceil(M/T). busy stays high for exactly those N·T cycles.
- R5: done is high for a single cycle, and busy is low whenever done is high.
- R6: While busy, a start pulse and any change on a_in, b_in or poly_in have no effect on the result or on its timing.
- R7: While busy is low and start is low, y holds its value.
- R8: For the same operands, T = 1 (one row, M rounds) and T = M (M rows, one round) give the same y as any other T.
- R9: A = 0 or B = 0 gives y = 0, and B = 1 gives y = A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| a_in | input | M | Operand A, coefficient j on bit j |
| b_in | input | M | Operand B, coefficient j on bit j |
| poly_in | input | M | Coefficients x^0..x^(M-1) of P; the x^M term is implied |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when y carries the result |
| y | output | M | Result A·B² mod P |

## Verification
The hardest situation to reach from the ports is a start pulse and fresh operands arriving in the middle of an operation, while the rows are part-way through a round. The stimulus raises start and re-randomises every operand two cycles into selected operations. It then expects the originally captured result, on the original schedule.

Several fold factors run side by side on the same operands: one row, one full round of M rows, and an uneven split with zero padding. This shows that the digit walk and the round feedback agree whether or not the last digit is padded.

// File: rtl/gf_sqmul_pkg.sv
// Shared types for the folded A*B^2 unit.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package gf_sqmul_pkg;

    // Controller state: waiting for start, or walking rounds.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sq_state_e;

    // Ceiling division used to derive the round count.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/gf_sqmul_pprime.sv
// Derives the reduced form of x^(M+1) from the low coefficients of P.
// Assumes x^M = sum poly[j] x^j; then x^(M+1) = x*x^M is reduced once more.
module gf_sqmul_pprime #(
    parameter int M = 8
) (
    input  logic [M-1:0] poly,
    output logic [M-1:0] poly_hi
);

    // Bit 0 receives only the wrapped top coefficient.
    assign poly_hi[0] = poly[M-1] & poly[0];

    // Higher bits: shifted coefficient plus wrapped top coefficient.
    for (genvar j = 1; j < M; j++) begin : g_hi
        assign poly_hi[j] = (poly[M-1] & poly[j]) ^ poly[j-1];
    end

endmodule

// File: rtl/gf_sqmul_row.sv
// One array row: s_out = s_in * x^2 + a_op * bit_b, reduced mod P.
// Assumes M >= 2 and poly_hi = x^(M+1) mod P supplied by the caller.
module gf_sqmul_row #(
    parameter int M = 8
) (
    input  logic [M-1:0] s_in,
    input  logic [M-1:0] a_op,
    input  logic [M-1:0] poly,
    input  logic [M-1:0] poly_hi,
    input  logic         bit_b,
    output logic [M-1:0] s_out
);

    // Overflow bits that fold back through x^M and x^(M+1).
    logic ovf_lo;
    logic ovf_hi;
    assign ovf_lo = s_in[M-2];
    assign ovf_hi = s_in[M-1];

    for (genvar j = 0; j < M; j++) begin : g_bit
        if (j < 2) begin : g_low
            // Low two bits have no shifted-in term.
            assign s_out[j] = (ovf_lo & poly[j]) ^ (ovf_hi & poly_hi[j])
                            ^ (a_op[j] & bit_b);
        end else begin : g_mid
            // Remaining bits take the term shifted up by two.
            assign s_out[j] = s_in[j-2] ^ (ovf_lo & poly[j])
                            ^ (ovf_hi & poly_hi[j]) ^ (a_op[j] & bit_b);
        end
    end

endmodule

// File: rtl/gf_sqmul_array.sv
// Folded array of T rows, each followed by its own stage register.
// Row r loads only in slot r of a round; row 0 takes zero in the first
// round and the last stage's value in later rounds.
module gf_sqmul_array #(
    parameter int M  = 8,
    parameter int T  = 3,
    parameter int CW = (T > 1) ? $clog2(T) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] slot,
    input  logic          first_rnd,
    input  logic [T-1:0]  digit,
    input  logic [M-1:0]  a_op,
    input  logic [M-1:0]  poly,
    input  logic [M-1:0]  poly_hi,
    output logic [M-1:0]  result
);

    logic [M-1:0] stg     [T];
    logic [M-1:0] row_in  [T];
    logic [M-1:0] row_out [T];

    for (genvar r = 0; r < T; r++) begin : g_row
        if (r == 0) begin : g_head
            // Head row: zero seed in round 0, feedback afterwards.
            assign row_in[r] = first_rnd ? '0 : stg[T-1];
        end else begin : g_body
            // Other rows chain from the previous stage.
            assign row_in[r] = stg[r-1];
        end

        gf_sqmul_row #(.M(M)) u_row (
            .s_in    (row_in[r]),
            .a_op    (a_op),
            .poly    (poly),
            .poly_hi (poly_hi),
            .bit_b   (digit[T-1-r]),
            .s_out   (row_out[r])
        );

        // Stage register: loads in this row's slot only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[r] <= '0;
            end else if (run && (slot == CW'(r))) begin
                stg[r] <= row_out[r];
            end
        end
    end

    assign result = stg[T-1];

endmodule

// File: rtl/gf_sqmul_ctrl.sv
// Round and slot sequencer for the folded array.
// Assumes start is ignored while running; done pulses after the last slot.
module gf_sqmul_ctrl
    import gf_sqmul_pkg::*;
#(
    parameter int T  = 3,
    parameter int N  = 3,
    parameter int CW = (T > 1) ? $clog2(T) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          capture,
    output logic          run,
    output logic [CW-1:0] slot,
    output logic          first_rnd,
    output logic          rnd_end,
    output logic          busy,
    output logic          done
);

    localparam int RW = (N > 1) ? $clog2(N) : 1;

    sq_state_e     state;
    logic [RW-1:0] rnd;
    logic          last_slot;
    logic          last_rnd;

    assign run       = (state == ST_RUN);
    assign busy      = run;
    assign capture   = (state == ST_IDLE) && start;
    assign last_slot = (slot == CW'(T - 1));
    assign last_rnd  = (rnd == RW'(N - 1));
    assign first_rnd = (rnd == '0);
    assign rnd_end   = run && last_slot;

    // Sequencer: slot counter inside rounds, round counter, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
            rnd   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (capture) begin
                state <= ST_RUN;
                slot  <= '0;
                rnd   <= '0;
            end else if (run) begin
                if (last_slot) begin
                    slot <= '0;
                    if (last_rnd) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        rnd <= rnd + 1'b1;
                    end
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gf_sqmul_fold.sv
// Top: folded A*B^2 mod P unit with T rows reused over ceil(M/T) rounds.
// Assumes M >= 2 and 1 <= T <= M; operands are captured on start.
module gf_sqmul_fold
    import gf_sqmul_pkg::*;
#(
    parameter int M = 8,
    parameter int T = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    input  logic [M-1:0] poly_in,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] y
);

    localparam int N  = ceil_div(M, T);
    localparam int NB = N * T;
    localparam int CW = (T > 1) ? $clog2(T) : 1;

    logic [M-1:0]  a_q;
    logic [M-1:0]  p_q;
    logic [M-1:0]  p_hi;
    logic [NB-1:0] b_sh;
    logic          capture;
    logic          run;
    logic [CW-1:0] slot;
    logic          first_rnd;
    logic          rnd_end;

    // Operand capture; the digit register advances one digit per round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            p_q  <= '0;
            b_sh <= '0;
        end else if (capture) begin
            a_q  <= a_in;
            p_q  <= poly_in;
            b_sh <= NB'(b_in);
        end else if (rnd_end) begin
            b_sh <= b_sh << T;
        end
    end

    gf_sqmul_pprime #(.M(M)) u_pp (
        .poly    (p_q),
        .poly_hi (p_hi)
    );

    gf_sqmul_ctrl #(.T(T), .N(N), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .capture   (capture),
        .run       (run),
        .slot      (slot),
        .first_rnd (first_rnd),
        .rnd_end   (rnd_end),
        .busy      (busy),
        .done      (done)
    );

    gf_sqmul_array #(.M(M), .T(T), .CW(CW)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .slot      (slot),
        .first_rnd (first_rnd),
        .digit     (b_sh[NB-1 -: T]),
        .a_op      (a_q),
        .poly      (p_q),
        .poly_hi   (p_hi),
        .result    (y)
    );

endmodule

// File: rtl/gf_sqmul_chk.sv
// Protocol checker for gf_sqmul_fold, attached by bind below.
// Counts busy cycles itself so the latency window needs no long $past.
module gf_sqmul_chk
    import gf_sqmul_pkg::*;
#(
    parameter int M = 8,
    parameter int T = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [M-1:0] a_in,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] y
);

    localparam int N = ceil_div(M, T);

    int           bcnt;
    logic [M-1:0] a_cap;

    // Busy-cycle counter and operand copy, restarted at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt  <= 0;
            a_cap <= '0;
        end else if (!busy && start) begin
            bcnt  <= 0;
            a_cap <= a_in;
        end else if (busy) begin
            bcnt <= bcnt + 1;
        end
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == N * T));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(y));

    assert_zero_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (a_cap == '0)) |-> (y == '0));

endmodule

bind gf_sqmul_fold gf_sqmul_chk #(.M(M), .T(T)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .a_in  (a_in),
    .busy  (busy),
    .done  (done),
    .y     (y)
);

// File: tb/sim_gf_sqmul_fold.sv
`timescale 1ns/1ps
module sim_gf_sqmul_fold;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        st8 = 1'b0, st13 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0, p8 = '0;
    logic [12:0] a13 = '0, b13 = '0, p13 = '0;

    logic [5:0]  done_w, busy_w;
    logic [15:0] y_w [6];
    logic [7:0]  y0, y1, y2;
    logic [12:0] y3, y4, y5;

    int nchk = 0, nerr = 0, cyc = 0;
    int m_of [6] = '{8, 8, 8, 13, 13, 13};
    int t_of [6] = '{3, 1, 8, 1, 4, 13};

    gf_sqmul_fold #(.M(8), .T(3)) u0 (.clk(clk), .rst_n(rst_n), .start(st8),
        .a_in(a8), .b_in(b8), .poly_in(p8), .busy(busy_w[0]), .done(done_w[0]), .y(y0));
    gf_sqmul_fold #(.M(8), .T(1)) u1 (.clk(clk), .rst_n(rst_n), .start(st8),
        .a_in(a8), .b_in(b8), .poly_in(p8), .busy(busy_w[1]), .done(done_w[1]), .y(y1));
    gf_sqmul_fold #(.M(8), .T(8)) u2 (.clk(clk), .rst_n(rst_n), .start(st8),
        .a_in(a8), .b_in(b8), .poly_in(p8), .busy(busy_w[2]), .done(done_w[2]), .y(y2));
    gf_sqmul_fold #(.M(13), .T(1)) u3 (.clk(clk), .rst_n(rst_n), .start(st13),
        .a_in(a13), .b_in(b13), .poly_in(p13), .busy(busy_w[3]), .done(done_w[3]), .y(y3));
    gf_sqmul_fold #(.M(13), .T(4)) u4 (.clk(clk), .rst_n(rst_n), .start(st13),
        .a_in(a13), .b_in(b13), .poly_in(p13), .busy(busy_w[4]), .done(done_w[4]), .y(y4));
    gf_sqmul_fold #(.M(13), .T(13)) u5 (.clk(clk), .rst_n(rst_n), .start(st13),
        .a_in(a13), .b_in(b13), .poly_in(p13), .busy(busy_w[5]), .done(done_w[5]), .y(y5));

    assign y_w[0] = 16'(y0);
    assign y_w[1] = 16'(y1);
    assign y_w[2] = 16'(y2);
    assign y_w[3] = 16'(y3);
    assign y_w[4] = 16'(y4);
    assign y_w[5] = 16'(y5);

    // Bit-serial reference multiply mod P, highest multiplier bit first.
    function automatic logic [15:0] gmul(input logic [15:0] x, input logic [15:0] z,
                                         input logic [15:0] p, input int m);
        logic [15:0] mask = 16'((32'd1 << m) - 1);
        logic [15:0] r = '0;
        for (int i = m - 1; i >= 0; i--) begin
            logic top = r[m-1];
            r = (r << 1) & mask;
            if (top) r = r ^ (p & mask);
            if (z[i]) r = r ^ (x & mask);
        end
        return r;
    endfunction

    function automatic logic [15:0] gsq(input logic [15:0] x, input logic [15:0] z,
                                        input logic [15:0] p, input int m);
        return gmul(gmul(x, z, p, m), z, p, m);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R4 actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    // One operation on both groups; optional disturbance while busy (R6).
    task automatic run_op(input logic [7:0] a8v, input logic [7:0] b8v, input logic [7:0] p8v,
                          input logic [12:0] a13v, input logic [12:0] b13v, input logic [12:0] p13v,
                          input bit disturb, input string tg);
        logic [15:0] exp_y [6];
        logic [15:0] got [6];
        int lat [6];
        bit seen [6];
        for (int i = 0; i < 6; i++) begin
            exp_y[i] = (i < 3) ? gsq(16'(a8v), 16'(b8v), 16'(p8v), 8)
                               : gsq(16'(a13v), 16'(b13v), 16'(p13v), 13);
            got[i] = '0; lat[i] = 0; seen[i] = 1'b0;
        end
        @(negedge clk);
        a8 = a8v; b8 = b8v; p8 = p8v; a13 = a13v; b13 = b13v; p13 = p13v;
        st8 = 1'b1; st13 = 1'b1;
        @(negedge clk);
        st8 = 1'b0; st13 = 1'b0;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            if (k == 1)
                for (int i = 0; i < 6; i++) check($sformatf("R2 busy u%0d", i), 16'(busy_w[i]), 16'd1);
            if (disturb && k == 2) begin
                st8 = 1'b1; st13 = 1'b1;
            end
            if (k == 3) begin
                st8 = 1'b0; st13 = 1'b0;
            end
            if (k == 2 || k == 20) begin
                a8 = 8'($urandom); b8 = 8'($urandom); p8 = 8'($urandom);
                a13 = 13'($urandom); b13 = 13'($urandom); p13 = 13'($urandom);
            end
            for (int i = 0; i < 6; i++) begin
                if (!seen[i] && done_w[i]) begin
                    seen[i] = 1'b1; lat[i] = k; got[i] = y_w[i];
                    check($sformatf("R5 busy low at done u%0d", i), 16'(busy_w[i]), 16'd0);
                end else if (seen[i] && k == lat[i] + 1) begin
                    check($sformatf("R5 pulse u%0d", i), 16'(done_w[i]), 16'd0);
                end
            end
        end
        for (int i = 0; i < 6; i++) begin
            string rt;
            int n_r = (m_of[i] + t_of[i] - 1) / t_of[i];
            if (tg.len() != 0) rt = tg;
            else if (disturb) rt = "R6";
            else if (t_of[i] == 1) rt = "R8 t=1";
            else if (t_of[i] == m_of[i]) rt = "R8 t=m";
            else rt = "R3";
            check($sformatf("R4 latency u%0d", i), 16'(lat[i]), 16'(n_r * t_of[i]));
            check($sformatf("%s result u%0d", rt, i), got[i], exp_y[i]);
            check($sformatf("R7 hold u%0d", i), y_w[i], got[i]);
        end
    endtask

    initial begin
        void'($urandom(32'h0051_AB2F));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            check($sformatf("R1 busy u%0d", i), 16'(busy_w[i]), 16'd0);
            check($sformatf("R1 done u%0d", i), 16'(done_w[i]), 16'd0);
            check($sformatf("R1 y u%0d", i), y_w[i], 16'd0);
        end
        // Directed corners (R9 and all-ones), field polynomials x^8+x^4+x^3+x+1, x^13+x^4+x^3+x+1.
        run_op(8'h00, 8'hA7, 8'h1B, 13'h0000, 13'h1ABC, 13'h001B, 1'b0, "R9 A=0");
        run_op(8'h5C, 8'h00, 8'h1B, 13'h0F0F, 13'h0000, 13'h001B, 1'b0, "R9 B=0");
        run_op(8'hC3, 8'h01, 8'h1B, 13'h1234, 13'h0001, 13'h001B, 1'b0, "R9 B=1");
        run_op(8'hFF, 8'hFF, 8'h1B, 13'h1FFF, 13'h1FFF, 13'h001B, 1'b0, "");
        run_op(8'h80, 8'h80, 8'hFF, 13'h1000, 13'h1000, 13'h1FFF, 1'b0, "");
        // Random operands and random reduction polynomials.
        for (int r = 0; r < 40; r++) begin
            run_op(8'($urandom), 8'($urandom), 8'($urandom) | 8'h01,
                   13'($urandom), 13'($urandom), 13'($urandom) | 13'h0001,
                   (r % 4) == 1, "");
        end
        summary();
        $finish;
    end

endmodule